// File: doc/BRIEF.md
# Shadow-Buffered Multi-Channel Pulse-Width Modulator

This block produces several independent pulse-width modulated outputs. Each one is programmed through a small word-addressed register port. Every channel holds two unsigned counts, both measured in cycles of the block clock. One count sets how long the output stays high at the start of each cycle. The other sets the length of the whole cycle. Each waveform starts with its high phase, drops low for the rest of the period, and then repeats.

Software writes land in a programmable copy of each count. A running channel moves these values into its working copy only when its current period ends, so a waveform is never cut in the middle of a period. When both working counts are zero the channel is stopped and its output is held high. A stopped channel takes up new nonzero values on the very next clock and starts its counter from zero. Reads return the programmed values, including values that are still waiting for a period boundary.

Top module: `shadow_pwm`

## Requirements
- R1: After reset, every register reads back zero and every bit of `pwm_out` is 1.
- R2: For channel c, the high-time register sits at byte offset 8*c and the period register at 8*c+4. A read returns the last value written to that register, even if the value has not yet reached the channel.
- R3: An offset with either of its two low bits set, or with a channel index (offset bits above bit 2) of NUM_CH or more, is unmapped. A write there changes no register and no output, and a read there returns zero.
- R4: Read data appears on `reg_rdata` one clock after the address is presented and stays unchanged until that edge.
- R5: A running channel with high time H and period P, where 0 < H < P, drives its output high for H cycles and then low for P-H cycles. Every period begins with the high phase.
- R6: When the period is nonzero and the high time is greater than or equal to it, the output stays high for the whole period.
- R7: When the high time is zero and the period is nonzero, the output stays low.
- R8: New values written to a running channel do not affect its output until the current period has finished. From the next period on, the channel uses the new values.
- R9: Once a channel's working high time and period are both zero, its output is held high. A stop written to a running channel takes effect at the period boundary.
- R10: A stopped channel loads nonzero programmed values on the clock edge after the write and starts its period at count zero, without waiting for any boundary.
- R11: Programming one channel leaves the outputs of the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all counts are in its cycles |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Byte offset of the register being read or written |
| reg_we | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data, valid one clock after the address |
| pwm_out | output | NUM_CH | One registered waveform output per channel |

## Verification
The bench builds the block with NUM_CH=4 and DATA_W=32. It widens ADDR_W to 6, so offsets 0x20 to 0x3C fall inside the address space but lie above the last channel. This lets it test writes and reads at unmapped offsets beyond the register map as well as at unaligned offsets inside it. Small counts (periods up to 20 cycles) make it practical to check whole waveforms cycle by cycle. They also bring within reach the precise sample at which a rewrite takes effect mid-period, a stopped channel starts up, and a stop lands on a running channel.

// File: rtl/shadow_pwm_pkg.sv
package shadow_pwm_pkg;
  // Each channel occupies an 8-byte slot: high-time word then period word.
  localparam int SLOT_LG  = 3;
  // Address bit that selects the period word within a slot.
  localparam int KIND_BIT = 2;

  typedef enum logic {
    REG_HIGH   = 1'b0,
    REG_PERIOD = 1'b1
  } reg_kind_e;
endpackage

// File: rtl/spwm_addr_dec.sv
module spwm_addr_dec
  import shadow_pwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 5,
  localparam int IDX_W = ADDR_W - SLOT_LG
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output reg_kind_e         kind,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [IDX_W:0] CH_LIM = (IDX_W+1)'(NUM_CH);

  assign idx  = addr[ADDR_W-1:SLOT_LG];
  assign kind = reg_kind_e'(addr[KIND_BIT]);
  assign hit  = (addr[KIND_BIT-1:0] == '0) && ({1'b0, idx} < CH_LIM);
endmodule

// File: rtl/spwm_regs.sv
module spwm_regs
  import shadow_pwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  localparam int IDX_W = ADDR_W - SLOT_LG
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           we,
  input  logic [DATA_W-1:0]              wdata,
  input  logic                           hit,
  input  reg_kind_e                      kind,
  input  logic [IDX_W-1:0]               idx,
  output logic [DATA_W-1:0]              rdata,
  output logic [NUM_CH-1:0][DATA_W-1:0]  sw_hi,
  output logic [NUM_CH-1:0][DATA_W-1:0]  sw_per
);
  logic [DATA_W-1:0] rd_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_hi  <= '0;
      sw_per <= '0;
    end else if (we && hit) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (idx == IDX_W'(c)) begin
          if (kind == REG_PERIOD) sw_per[c] <= wdata;
          else                    sw_hi[c]  <= wdata;
        end
      end
    end
  end

  always_comb begin
    rd_sel = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (hit && idx == IDX_W'(c))
        rd_sel = (kind == REG_PERIOD) ? sw_per[c] : sw_hi[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_sel;
  end

  // R3
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (rst)
    !hit |=> rdata == '0);

  // R3
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (we && !hit) |=> ($stable(sw_hi) && $stable(sw_per)));
endmodule

// File: rtl/spwm_channel.sv
module spwm_channel #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] sw_hi,
  input  logic [DATA_W-1:0] sw_per,
  output logic              out_q
);
  logic [DATA_W-1:0] act_hi, act_per, cnt;
  logic [DATA_W-1:0] nxt_hi, nxt_per, nxt_cnt;
  logic [DATA_W:0]   cnt_inc;
  logic              idle, last, load, nxt_out;

  always_comb begin
    cnt_inc = {1'b0, cnt} + 1'b1;
    idle    = (act_per == '0) && (act_hi == '0);
    last    = cnt_inc >= {1'b0, act_per};
    load    = idle || last;
    nxt_hi  = load ? sw_hi  : act_hi;
    nxt_per = load ? sw_per : act_per;
    nxt_cnt = load ? '0 : cnt_inc[DATA_W-1:0];
    if (nxt_per == '0 && nxt_hi == '0) nxt_out = 1'b1;
    else                               nxt_out = nxt_cnt < nxt_hi;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_hi  <= '0;
      act_per <= '0;
      cnt     <= '0;
      out_q   <= 1'b1;
    end else begin
      act_hi  <= nxt_hi;
      act_per <= nxt_per;
      cnt     <= nxt_cnt;
      out_q   <= nxt_out;
    end
  end

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    (act_per != '0) |-> (cnt < act_per));

  // R6
  full_high_chk: assert property (@(posedge clk) disable iff (rst)
    (act_per != '0 && act_hi >= act_per) |-> out_q);

  // R8
  mid_period_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!idle && !last) |=> ($stable(act_hi) && $stable(act_per)));

  // R9
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    (act_per == '0 && act_hi == '0) |-> out_q);

  // R10
  idle_pickup_chk: assert property (@(posedge clk) disable iff (rst)
    idle |=> (act_hi == $past(sw_hi) && act_per == $past(sw_per) && cnt == '0));
endmodule

// File: rtl/shadow_pwm.sv
module shadow_pwm
  import shadow_pwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  localparam int IDX_W = ADDR_W - SLOT_LG;

  logic                          dec_hit;
  reg_kind_e                     dec_kind;
  logic [IDX_W-1:0]              dec_idx;
  logic [NUM_CH-1:0][DATA_W-1:0] sw_hi, sw_per;

  spwm_addr_dec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .addr (reg_addr),
    .hit  (dec_hit),
    .kind (dec_kind),
    .idx  (dec_idx)
  );

  spwm_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .we     (reg_we),
    .wdata  (reg_wdata),
    .hit    (dec_hit),
    .kind   (dec_kind),
    .idx    (dec_idx),
    .rdata  (reg_rdata),
    .sw_hi  (sw_hi),
    .sw_per (sw_per)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    spwm_channel #(.DATA_W(DATA_W)) u_ch (
      .clk    (clk),
      .rst    (rst),
      .sw_hi  (sw_hi[c]),
      .sw_per (sw_per[c]),
      .out_q  (pwm_out[c])
    );
  end
endmodule

// File: tb/shadow_pwm_tb.sv
module shadow_pwm_tb;
  localparam int NUM_CH = 4;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic              reg_we = 1'b0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic [NUM_CH-1:0] pwm_out;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  shadow_pwm #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
  );

  typedef struct packed {
    logic [7:0]  ch;
    logic [31:0] hi;
    logic [31:0] per;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{8'd0, 32'd3,  32'd8},
    '{8'd2, 32'd1,  32'd2},
    '{8'd3, 32'd5,  32'd6},
    '{8'd0, 32'd10, 32'd10},
    '{8'd2, 32'd0,  32'd5},
    '{8'd3, 32'd12, 32'd7},
    '{8'd1, 32'd7,  32'd20}
  };

  function automatic logic [ADDR_W-1:0] a(int ch, bit per);
    return ADDR_W'(ch * 8 + (per ? 4 : 0));
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] ad, logic [DATA_W-1:0] d);
    @(negedge clk);
    reg_addr = ad; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk);
    #1 reg_we = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] ad, output logic [DATA_W-1:0] d);
    @(negedge clk);
    reg_addr = ad;
    @(posedge clk);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_level(int ch, logic lvl);
    int t = 0;
    while (pwm_out[ch] !== lvl && t < 200) begin @(negedge clk); t++; end
  endtask

  task automatic count_run(int ch, logic lvl, output int n);
    n = 0;
    while (pwm_out[ch] === lvl && n < 200) begin n++; @(negedge clk); end
  endtask

  task automatic stop_ch(int ch);
    wr(a(ch, 0), 0);
    wr(a(ch, 1), 0);
    repeat (25) @(posedge clk);
  endtask

  initial begin
    wait (cyc >= 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] d;
    int nl, nh;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;

    // R1: reset state
    @(negedge clk);
    chk("R1", "outputs after reset", 32'(pwm_out), 32'hF);
    for (int c = 0; c < NUM_CH; c++) begin
      rd(a(c, 0), d); chk("R1", "high reg after reset", d, 0);
      rd(a(c, 1), d); chk("R1", "period reg after reset", d, 0);
    end

    // R3: unmapped writes ignored, reads zero
    wr(6'h20, 32'h55);
    wr(6'h24, 32'h66);
    wr(6'h02, 32'h77);
    wr(6'h05, 32'h88);
    rd(6'h20, d); chk("R3", "read above map", d, 0);
    rd(6'h02, d); chk("R3", "read unaligned", d, 0);
    rd(a(0, 0), d); chk("R3", "ch0 high untouched", d, 0);
    rd(a(0, 1), d); chk("R3", "ch0 period untouched", d, 0);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); chk("R3", "outputs stay idle", 32'(pwm_out), 32'hF);
    end

    // R10 + R11: stopped channel starts on next clock, others unchanged
    wr(a(0, 0), 2);
    wr(a(0, 1), 5);
    begin
      logic exp_seq [7] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
      for (int k = 0; k < 7; k++) begin
        @(negedge clk);
        chk("R10", "startup sample", 32'(pwm_out[0]), 32'(exp_seq[k]));
        chk("R11", "other channels idle", 32'(pwm_out[3:1]), 32'h7);
      end
    end
    stop_ch(0);

    // R2 + R4: map and readback
    for (int c = 0; c < NUM_CH; c++) begin
      wr(a(c, 0), 32'(c + 1));
      wr(a(c, 1), 32'(c + 9));
    end
    for (int c = 0; c < NUM_CH; c++) begin
      rd(a(c, 0), d); chk("R2", "high readback", d, 32'(c + 1));
      rd(a(c, 1), d); chk("R2", "period readback", d, 32'(c + 9));
    end
    rd(a(2, 0), d);
    @(negedge clk);
    reg_addr = a(2, 1);
    #1 chk("R4", "data before edge", reg_rdata, 3);
    @(posedge clk); @(negedge clk);
    chk("R4", "data after one edge", reg_rdata, 11);
    for (int c = 0; c < NUM_CH; c++) stop_ch(c);

    // R5/R6/R7: vector table
    for (int i = 0; i < NVEC; i++) begin
      int ch, eh, el;
      ch = int'(VECS[i].ch);
      eh = (VECS[i].hi < VECS[i].per) ? int'(VECS[i].hi) : int'(VECS[i].per);
      el = int'(VECS[i].per) - eh;
      stop_ch(ch);
      wr(a(ch, 0), VECS[i].hi);
      wr(a(ch, 1), VECS[i].per);
      @(negedge clk);
      if (el == 0) begin
        for (int k = 0; k < 3 * int'(VECS[i].per); k++) begin
          @(negedge clk); chk("R6", "high whole period", 32'(pwm_out[ch]), 1);
        end
      end else if (eh == 0) begin
        repeat (2) @(negedge clk);
        for (int k = 0; k < 3 * int'(VECS[i].per); k++) begin
          @(negedge clk); chk("R7", "zero high time low", 32'(pwm_out[ch]), 0);
        end
      end else begin
        wait_level(ch, 1'b0);
        count_run(ch, 1'b0, nl);
        count_run(ch, 1'b1, nh);
        chk("R5", "low run", 32'(nl), 32'(el));
        chk("R5", "high run", 32'(nh), 32'(eh));
      end
    end
    for (int c = 0; c < NUM_CH; c++) stop_ch(c);

    // R8: rewrite mid-period on channel 1
    wr(a(1, 0), 2);
    wr(a(1, 1), 10);
    begin
      logic p;
      int t = 0;
      @(negedge clk); p = pwm_out[1];
      forever begin
        @(negedge clk);
        t++;
        if ((!p && pwm_out[1]) || t > 100) break;
        p = pwm_out[1];
      end
    end
    reg_addr = a(1, 0); reg_wdata = 6; reg_we = 1'b1;
    @(posedge clk);
    #1 reg_we = 1'b0;
    for (int k = 0; k < 19; k++) begin
      logic e;
      e = (k == 0) || (k >= 9 && k <= 14);
      @(negedge clk);
      chk("R8", "sample around boundary", 32'(pwm_out[1]), 32'(e));
    end

    // R9: stop a running channel
    wr(a(1, 0), 0);
    wr(a(1, 1), 0);
    rd(a(1, 0), d); chk("R9", "stop readback", d, 0);
    repeat (12) @(posedge clk);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk); chk("R9", "held high when stopped", 32'(pwm_out[1]), 1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule